// File: doc/BRIEF.md
# Short-Circuit Hiccup and Over-Temperature Run Controller

This block decides, cycle by cycle, whether the output regulator of a supply channel may run. It watches a current-limit comparator, two die-temperature comparators (one that trips at the upper threshold and one that reports that the die has cooled below the lower threshold), and an external enable pin. When an overload appears, the regulator keeps running with its current clamped for a bounded window. If the overload is still present when the window ends, the regulator is switched off for a long rest period and then restarted automatically. An over-temperature trip overrides everything except the enable pin. After a trip, the output stays off until the cool comparator reports that the die has dropped through the whole hysteresis band.

Each protective shutdown produces a one-cycle event pulse for the status flags that sit next to the block, and it sets a latched fault indication. That indication is cleared in one of two ways, depending on whether register control is active: either a status read, or a low-then-high cycle on the enable pin. All timing counts a millisecond tick that is divided down from the system clock. Every asynchronous input passes through a two-flop synchronizer and then a four-sample agreement filter.

Top module: `hiccup_guard`

## Requirements
- R1: After reset, `run_en` is 0, `out_pull_low` is 1, `fault_latched` is 0, and neither event output is high.
- R2: While the filtered enable input is low, `run_en` is 0 and `out_pull_low` is 1. When the enable input is high with no fault condition present, `run_en` goes to 1 and `out_pull_low` goes to 0 within 20 clocks.
- R3: While the overcurrent input is active, `run_en` stays 1 for at most `CLAMP_MS` ticks. If the overcurrent input clears before the window ends, the window count restarts from zero on the next overload.
- R4: An overcurrent that persists for `CLAMP_MS` ticks drives `run_en` to 0 and raises `oc_event` for exactly one clock.
- R5: After an overcurrent shutdown, `run_en` stays 0 for `OFF_MS` ticks and then returns to 1 without any outside action.
- R6: A high over-temperature input drives `run_en` to 0 and raises `ot_event` for one clock. The output stays off while both temperature inputs are low (the hysteresis band), and it runs again only once the cool input is high and the trip input is low.
- R7: An over-temperature trip takes priority over the overcurrent rest period. When the rest period ends during a trip, no restart is made until the cool input reports recovery.
- R8: `fault_latched` is set by either event and stays set after the condition clears. With `regctl_on` = 0, a status read does not clear it, and a rising edge of the filtered enable clears it.
- R9: With `regctl_on` = 1, a one-clock `status_rd` pulse clears `fault_latched` at the next clock, and an enable cycle leaves it set. When an event and a clear request arrive together, the event wins.
- R10: An input pulse shorter than 4 clocks after synchronization has no effect. A 2-clock drop of the enable pin leaves `run_en` at 1. Short pulses on the overcurrent or trip input cause no event and no shutdown.
- R11: `oc_event` and `ot_event` are never high together, and each lasts one clock per shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_pin | input | 1 | External enable pin, asynchronous |
| oc_in | input | 1 | Overcurrent comparator, asynchronous, high = overload |
| ot_trip_in | input | 1 | Die above upper temperature threshold, asynchronous |
| ot_cool_in | input | 1 | Die below lower recovery threshold, asynchronous |
| regctl_on | input | 1 | Register control active (selects how the fault is cleared) |
| status_rd | input | 1 | One-clock pulse marking a read of the status flags |
| run_en | output | 1 | Regulator run enable |
| out_pull_low | output | 1 | Discharge the output node (enable pin low) |
| oc_event | output | 1 | One-clock pulse on an overcurrent shutdown |
| ot_event | output | 1 | One-clock pulse on a thermal shutdown |
| fault_latched | output | 1 | Latched fault indication |

## Verification
The assertions assume that the two temperature comparators never report "hot" and "cool" at the same time. They also assume that `status_rd` and `regctl_on` come from the same clock domain, so only the pin and comparator inputs go through the filter. The stimulus drives the temperature inputs only as the pairs (trip=1, cool=0), (trip=0, cool=0) and (trip=0, cool=1), and it changes every input on the falling clock edge. Timing checks sample well inside or well past each window. This is needed because the free-running tick gives every millisecond count a phase uncertainty of up to one tick, and filter latency adds about seven clocks on top of that.

// File: rtl/hiccup_guard_pkg.sv
package hiccup_guard_pkg;

    typedef enum logic [2:0] {
        ST_DISABLED = 3'd0,
        ST_RUN      = 3'd1,
        ST_CLAMP    = 3'd2,
        ST_HICCUP   = 3'd3,
        ST_THERM    = 3'd4
    } hg_state_e;

    // Filtered input bundle; bit order matches the conditioner vector.
    typedef struct packed {
        logic cool;
        logic hot;
        logic oc;
        logic en;
    } hg_in_s;

    localparam int HG_NIN = 4;

    function automatic logic hg_runs(hg_state_e s);
        return (s == ST_RUN) || (s == ST_CLAMP);
    endfunction

endpackage

// File: rtl/hg_tick.sv
module hg_tick #(
    parameter int DIV = 250000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/hg_cond.sv
module hg_cond #(
    parameter int N     = 4,
    parameter int SYNC  = 2,
    parameter int DEB   = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] clean
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [SYNC-1:0] chain;
        logic [DEB-1:0]  hist;
        logic            q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
                hist  <= '0;
                q     <= 1'b0;
            end else begin
                chain <= {chain[SYNC-2:0], raw[i]};
                hist  <= {hist[DEB-2:0], chain[SYNC-1]};
                if (&hist)       q <= 1'b1;
                else if (~|hist) q <= 1'b0;
            end
        end

        assign clean[i] = q;
    end
endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard
    import hiccup_guard_pkg::*;
#(
    parameter int CLK_PER_MS = 250000,
    parameter int CLAMP_MS   = 4,
    parameter int OFF_MS     = 128,
    parameter int SYNC_FF    = 2,
    parameter int DEB_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en_pin,
    input  logic oc_in,
    input  logic ot_trip_in,
    input  logic ot_cool_in,
    input  logic regctl_on,
    input  logic status_rd,
    output logic run_en,
    output logic out_pull_low,
    output logic oc_event,
    output logic ot_event,
    output logic fault_latched
);
    localparam int TMAX = (OFF_MS > CLAMP_MS) ? OFF_MS : CLAMP_MS;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] CLAMP_LAST = TW'(CLAMP_MS - 1);
    localparam logic [TW-1:0] OFF_LAST   = TW'(OFF_MS - 1);

    logic [HG_NIN-1:0] raw_vec, clean_vec;
    hg_in_s            c;
    logic              tick;

    assign raw_vec = {ot_cool_in, ot_trip_in, oc_in, en_pin};

    hg_cond #(.N(HG_NIN), .SYNC(SYNC_FF), .DEB(DEB_LEN)) u_cond (
        .clk   (clk),
        .rst   (rst),
        .raw   (raw_vec),
        .clean (clean_vec)
    );

    hg_tick #(.DIV(CLK_PER_MS)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign c = hg_in_s'(clean_vec);

    hg_state_e     state, nxt;
    logic [TW-1:0] tmr;
    logic          oc_nxt, ot_nxt;
    logic          en_prev;

    // Next-state: enable pin first, thermal second, then hiccup sequencing.
    always_comb begin
        nxt    = state;
        oc_nxt = 1'b0;
        ot_nxt = 1'b0;
        if (!c.en) begin
            nxt = ST_DISABLED;
        end else if (c.hot && state != ST_THERM) begin
            nxt    = ST_THERM;
            ot_nxt = 1'b1;
        end else begin
            case (state)
                ST_DISABLED: nxt = ST_RUN;
                ST_RUN:      if (c.oc) nxt = ST_CLAMP;
                ST_CLAMP: begin
                    if (!c.oc) begin
                        nxt = ST_RUN;
                    end else if (tick && tmr == CLAMP_LAST) begin
                        nxt    = ST_HICCUP;
                        oc_nxt = 1'b1;
                    end
                end
                ST_HICCUP:   if (tick && tmr == OFF_LAST) nxt = ST_RUN;
                ST_THERM:    if (c.cool && !c.hot) nxt = ST_RUN;
                default:     nxt = ST_DISABLED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_DISABLED;
            tmr      <= '0;
            oc_event <= 1'b0;
            ot_event <= 1'b0;
            en_prev  <= 1'b0;
        end else begin
            state    <= nxt;
            oc_event <= oc_nxt;
            ot_event <= ot_nxt;
            en_prev  <= c.en;
            if (nxt != state) tmr <= '0;
            else if (tick)    tmr <= tmr + 1'b1;
        end
    end

    // Latched fault: a new event wins over any clear request.
    logic clr_req;
    assign clr_req = regctl_on ? status_rd : (c.en && !en_prev);

    always_ff @(posedge clk) begin
        if (rst)                   fault_latched <= 1'b0;
        else if (oc_nxt || ot_nxt) fault_latched <= 1'b1;
        else if (clr_req)          fault_latched <= 1'b0;
    end

    assign run_en       = hg_runs(state);
    assign out_pull_low = (state == ST_DISABLED);
endmodule

// File: rtl/hiccup_guard_chk.sv
module hiccup_guard_chk
    import hiccup_guard_pkg::*;
#(
    parameter int CLAMP_CYC = 4,
    parameter int OFF_MIN   = 1
) (
    input logic      clk,
    input logic      rst,
    input logic      en_q,
    input logic      hot_q,
    input hg_state_e state,
    input logic      run_en,
    input logic      out_pull_low,
    input logic      oc_event,
    input logic      ot_event,
    input logic      fault_latched
);
    logic [31:0] clamp_cnt;
    logic [31:0] rest_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            clamp_cnt <= '0;
            rest_cnt  <= '0;
        end else begin
            clamp_cnt <= (state == ST_CLAMP) ? clamp_cnt + 1 : '0;
            if (state == ST_HICCUP)     rest_cnt <= rest_cnt + 1;
            else if (state == ST_CLAMP) rest_cnt <= '0;
        end
    end

    a_r2_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> (!run_en && out_pull_low));

    a_r6_off_when_hot: assert property (@(posedge clk) disable iff (rst)
        hot_q |=> !run_en);

    a_r11_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({oc_event, ot_event}));

    a_r11_oc_single_cycle: assert property (@(posedge clk) disable iff (rst)
        oc_event |=> !oc_event);

    a_r4_event_forces_off: assert property (@(posedge clk) disable iff (rst)
        (oc_event || ot_event) |-> !run_en);

    a_r8_event_sets_fault: assert property (@(posedge clk) disable iff (rst)
        (oc_event || ot_event) |-> fault_latched);

    a_r3_clamp_bounded: assert property (@(posedge clk) disable iff (rst)
        clamp_cnt <= CLAMP_CYC);

    a_r5_rest_long_enough: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_HICCUP && state == ST_RUN) |-> rest_cnt >= OFF_MIN);
endmodule

bind hiccup_guard hiccup_guard_chk #(
    .CLAMP_CYC (CLAMP_MS * CLK_PER_MS),
    .OFF_MIN   ((OFF_MS - 1) * CLK_PER_MS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .en_q          (c.en),
    .hot_q         (c.hot),
    .state         (state),
    .run_en        (run_en),
    .out_pull_low  (out_pull_low),
    .oc_event      (oc_event),
    .ot_event      (ot_event),
    .fault_latched (fault_latched)
);

// File: tb/hiccup_guard_test.sv
module hiccup_guard_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_pin = 1'b0, oc_in = 1'b0, ot_trip_in = 1'b0, ot_cool_in = 1'b0;
    logic regctl_on = 1'b0, status_rd = 1'b0;
    logic run_en, out_pull_low, oc_event, ot_event, fault_latched;

    int n_chk = 0, n_fail = 0;
    int n_oc = 0, n_ot = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hiccup_guard #(
        .CLK_PER_MS (8),
        .CLAMP_MS   (4),
        .OFF_MS     (128)
    ) uut (
        .clk, .rst, .en_pin, .oc_in, .ot_trip_in, .ot_cool_in,
        .regctl_on, .status_rd, .run_en, .out_pull_low,
        .oc_event, .ot_event, .fault_latched
    );

    always @(negedge clk) begin
        if (oc_event) n_oc++;
        if (ot_event) n_ot++;
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_run_fall(string req);
        int k = 0;
        while (run_en && k < 200) begin
            @(negedge clk);
            k++;
        end
        chk(req, run_en, 0);
    endtask

    task automatic t_reset;
        cyc(3);
        chk("R1 run_en", run_en, 0);
        chk("R1 pull", out_pull_low, 1);
        chk("R1 fault", fault_latched, 0);
        chk("R1 events", oc_event | ot_event, 0);
    endtask

    task automatic t_enable;
        ot_cool_in = 1'b1;
        en_pin = 1'b1;
        cyc(20);
        chk("R2 run on", run_en, 1);
        chk("R2 pull off", out_pull_low, 0);
    endtask

    task automatic t_short_oc;
        int bad = 0;
        int o0 = n_oc;
        oc_in = 1'b1;
        for (int i = 0; i < 16; i++) begin cyc(1); if (!run_en) bad++; end
        oc_in = 1'b0;
        for (int i = 0; i < 12; i++) begin cyc(1); if (!run_en) bad++; end
        oc_in = 1'b1;
        for (int i = 0; i < 16; i++) begin cyc(1); if (!run_en) bad++; end
        oc_in = 1'b0;
        for (int i = 0; i < 20; i++) begin cyc(1); if (!run_en) bad++; end
        chk("R3 window restarts", bad, 0);
        chk("R3 no oc event", n_oc - o0, 0);
        chk("R3 no fault", fault_latched, 0);
    endtask

    task automatic t_glitch;
        int bad = 0;
        int o0 = n_oc, t0 = n_ot;
        en_pin = 1'b0; cyc(2); en_pin = 1'b1;
        for (int i = 0; i < 15; i++) begin cyc(1); if (!run_en) bad++; end
        oc_in = 1'b1; cyc(3); oc_in = 1'b0;
        ot_trip_in = 1'b1; ot_cool_in = 1'b0; cyc(3);
        ot_trip_in = 1'b0; ot_cool_in = 1'b1;
        for (int i = 0; i < 60; i++) begin cyc(1); if (!run_en) bad++; end
        chk("R10 run held", bad, 0);
        chk("R10 no events", (n_oc - o0) + (n_ot - t0), 0);
        chk("R10 no fault", fault_latched, 0);
    endtask

    task automatic t_hiccup;
        int o0 = n_oc;
        oc_in = 1'b1;
        cyc(20);
        chk("R3 clamped but running", run_en, 1);
        wait_run_fall("R4 shut after window");
        oc_in = 1'b0;
        cyc(2);
        chk("R11 one oc pulse", n_oc - o0, 1);
        chk("R8 fault set", fault_latched, 1);
        cyc(998);
        chk("R5 still resting", run_en, 0);
        cyc(40);
        chk("R5 auto restart", run_en, 1);
        chk("R8 fault held", fault_latched, 1);
    endtask

    task automatic t_nonreg_clear;
        regctl_on = 1'b0;
        status_rd = 1'b1; cyc(1); status_rd = 1'b0; cyc(2);
        chk("R8 read ignored", fault_latched, 1);
        en_pin = 1'b0; cyc(20);
        chk("R2 off when low", run_en, 0);
        chk("R2 pull when low", out_pull_low, 1);
        chk("R8 held while low", fault_latched, 1);
        en_pin = 1'b1; cyc(20);
        chk("R8 cleared by cycle", fault_latched, 0);
        chk("R2 back on", run_en, 1);
    endtask

    task automatic t_thermal;
        int t0 = n_ot;
        ot_trip_in = 1'b1; ot_cool_in = 1'b0;
        cyc(20);
        chk("R6 off when hot", run_en, 0);
        chk("R6 one ot pulse", n_ot - t0, 1);
        chk("R8 fault by thermal", fault_latched, 1);
        ot_trip_in = 1'b0;
        cyc(60);
        chk("R6 off in band", run_en, 0);
        ot_cool_in = 1'b1;
        cyc(20);
        chk("R6 on after cool", run_en, 1);
    endtask

    task automatic t_reg_clear;
        regctl_on = 1'b1;
        en_pin = 1'b0; cyc(20); en_pin = 1'b1; cyc(20);
        chk("R9 cycle ignored", fault_latched, 1);
        status_rd = 1'b1; cyc(1); status_rd = 1'b0;
        chk("R9 read clears", fault_latched, 0);
    endtask

    task automatic t_priority;
        oc_in = 1'b1;
        wait_run_fall("R4 trip before thermal");
        ot_trip_in = 1'b1; ot_cool_in = 1'b0;
        oc_in = 1'b0;
        cyc(1100);
        chk("R7 no retry while hot", run_en, 0);
        ot_trip_in = 1'b0; ot_cool_in = 1'b1;
        cyc(20);
        chk("R7 restart after cool", run_en, 1);
    endtask

    initial begin
        cyc(4);
        rst = 1'b0;
        t_reset();
        t_enable();
        t_short_oc();
        t_glitch();
        t_hiccup();
        t_nonreg_clear();
        t_thermal();
        t_reg_clear();
        t_priority();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule